// File: doc/BRIEF.md
# Readout Pixel Classifier and Colour Tagger

This block runs next to the horizontal readout of a colour area sensor. It counts the pixel periods of each line and tags every period with the segment it belongs to. The segments are leading prescan elements, shielded dark references, isolation columns, the useful image columns and, past the expected length of the line, an overrun segment. For useful columns on image lines it also gives the colour of the mosaic site, from the parity of the image row and the parity of the useful column. The lines at the top and at the bottom of the frame are photosensitive padding rows, and they are flagged so that later stages can discard them.

A frame-start pulse restarts the line numbering and a line-start pulse opens each new line. A split-readout input halves the useful width when two outputs share one register. Each accepted pixel strobe produces one registered tag on the following clock edge.

Top module: `rdo_pixel_tagger`

## Requirements
- R1: While reset is high, and on the first cycle after it, `tag_valid` is 0 and `tag_region`, `tag_colour`, `tag_col` and `tag_dummy` are all 0.
- R2: A `pix_stb` sampled high, with `line_start` low, at a clock edge gives exactly one `tag_valid` pulse, visible right after that edge. There is no tag without a strobe.
- R3: Within a line the strobe position p (counted from 0 after `line_start`) maps to these region codes: p 0..11 gives 0 (prescan), p 12..27 gives 1 (dark reference), p 28..35 gives 2 (isolation), and p from 36 on gives 3 (useful).
- R4: The useful segment holds 2300 strobes when `split_out`=0 and 1150 when `split_out`=1. `tag_col` gives the 0-based useful column index p-36.
- R5: Every strobe after the useful segment of a line is tagged with region code 4 (overrun), with `tag_col`=0 and `tag_colour`=0, however many such strobes arrive.
- R6: `line_start` puts the position back to 0. A strobe in the same cycle as `line_start` is dropped and produces no tag.
- R7: After `frame_start`, the next line opened is line 0. When `frame_start` and `line_start` arrive together, that line is line 0.
- R8: Lines 0..3 and lines 3504 and above are padding lines. Their tags carry `tag_dummy`=1 and `tag_colour`=0. All other lines carry `tag_dummy`=0.
- R9: Colour codes are 0 red, 1 green and 2 blue. On image lines the row parity starts at even on line 4 and flips on each further image line. An even row gives blue on even columns and green on odd columns. An odd row gives green on even columns and red on odd columns.
- R10: Tags outside the useful segment always carry `tag_colour`=0 and `tag_col`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_stb | input | 1 | One pixel period of the horizontal readout |
| line_start | input | 1 | Opens a new line |
| frame_start | input | 1 | Restarts the line numbering |
| split_out | input | 1 | 1 when two outputs share the register (half width) |
| tag_valid | output | 1 | A tag is present this cycle |
| tag_region | output | 3 | Region code (0 prescan, 1 dark, 2 isolation, 3 useful, 4 overrun) |
| tag_colour | output | 2 | Mosaic colour (0 red, 1 green, 2 blue) |
| tag_col | output | 12 | Useful column index |
| tag_dummy | output | 1 | Tag belongs to a padding line |

## Verification
On every cycle the assertions check the cycle relation between strobe and tag, the dropping of strobes that coincide with line-start, the bound on the position counter, the zero colour and column outside the useful segment, the absence of colour code 3, and that adjacent useful columns of an image row never share a colour. Only the bench scenarios can show the exact segment boundaries for both widths, the row parity across thousands of lines, the padding rows at both ends of the frame, and the restart of the numbering after a frame pulse, alone or together with a line pulse.

// File: rtl/rdo_tag_pkg.sv
package rdo_tag_pkg;

    localparam int PRESCAN_LEN_D   = 12;
    localparam int DARK_LEN_D      = 16;
    localparam int ISOL_LEN_D      = 8;
    localparam int USEFUL_LEN_D    = 2300;
    localparam int LINES_TOTAL_D   = 3508;
    localparam int PAD_LINES_D     = 4;

    typedef enum logic [2:0] {
        RGN_PRESCAN = 3'd0,
        RGN_DARK    = 3'd1,
        RGN_ISOL    = 3'd2,
        RGN_USEFUL  = 3'd3,
        RGN_OVERRUN = 3'd4
    } region_e;

    typedef enum logic [1:0] {
        CLR_RED   = 2'd0,
        CLR_GREEN = 2'd1,
        CLR_BLUE  = 2'd2
    } colour_e;

    typedef struct packed {
        region_e region;
        logic    useful;
    } seg_t;

    // Even row: blue/green sites; odd row: green/red sites.
    function automatic colour_e site_colour(input logic row_odd, input logic col_odd);
        if (!row_odd) return col_odd ? CLR_GREEN : CLR_BLUE;
        else          return col_odd ? CLR_RED   : CLR_GREEN;
    endfunction

endpackage

// File: rtl/rdo_line_track.sv
module rdo_line_track
    import rdo_tag_pkg::*;
#(
    parameter int LINES_TOTAL = LINES_TOTAL_D,
    parameter int PAD_LINES   = PAD_LINES_D,
    parameter int LINE_W      = $clog2(LINES_TOTAL + 1)
)(
    input  logic clk,
    input  logic rst,
    input  logic line_start,
    input  logic frame_start,
    output logic line_pad,
    output logic row_odd
);
    localparam logic [LINE_W-1:0] LINE_SAT  = '1;
    localparam int                IMG_FIRST = PAD_LINES;
    localparam int                IMG_END   = LINES_TOTAL - PAD_LINES;

    logic [LINE_W-1:0] next_line_q;
    logic [LINE_W-1:0] base_line;
    logic              image_q;
    logic              row_odd_q;
    logic              base_is_image;

    always_comb begin
        base_line     = frame_start ? '0 : next_line_q;
        base_is_image = (int'(base_line) >= IMG_FIRST) && (int'(base_line) < IMG_END);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            next_line_q <= '0;
            image_q     <= 1'b0;
            row_odd_q   <= 1'b0;
        end else if (line_start) begin
            next_line_q <= (base_line == LINE_SAT) ? base_line : base_line + 1'b1;
            image_q     <= base_is_image;
            if (base_is_image)
                row_odd_q <= image_q ? ~row_odd_q : 1'b0;
        end else if (frame_start) begin
            next_line_q <= '0;
        end
    end

    assign line_pad = ~image_q;
    assign row_odd  = row_odd_q;

    // R7: a line opened together with a frame pulse is line 0, a padding line
    assert_frame_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (frame_start && line_start) |=> line_pad);

    // R9: row parity only moves when a line opens
    assert_row_stable_R9: assert property (@(posedge clk) disable iff (rst)
        !line_start |=> $stable(row_odd));

endmodule

// File: rtl/rdo_pos_count.sv
module rdo_pos_count #(
    parameter int LINE_MAX = 2336,
    parameter int POS_W    = $clog2(LINE_MAX + 1)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             line_start,
    input  logic             pix_stb,
    output logic [POS_W-1:0] pos
);
    localparam logic [POS_W-1:0] POS_SAT = POS_W'(LINE_MAX);

    always_ff @(posedge clk) begin
        if (rst || line_start)
            pos <= '0;
        else if (pix_stb && pos != POS_SAT)
            pos <= pos + 1'b1;
    end

    // R5: the position saturates at the end of the longest line
    assert_pos_bound_R5: assert property (@(posedge clk) disable iff (rst)
        pos <= POS_SAT);

    // R6: a line pulse returns the position to zero
    assert_pos_clear_R6: assert property (@(posedge clk) disable iff (rst)
        line_start |=> pos == '0);

endmodule

// File: rtl/rdo_region_map.sv
module rdo_region_map
    import rdo_tag_pkg::*;
#(
    parameter int PRESCAN_LEN = PRESCAN_LEN_D,
    parameter int DARK_LEN    = DARK_LEN_D,
    parameter int ISOL_LEN    = ISOL_LEN_D,
    parameter int USEFUL_LEN  = USEFUL_LEN_D,
    parameter int POS_W       = 12,
    parameter int COL_W       = 12
)(
    input  logic [POS_W-1:0] pos,
    input  logic             split_out,
    output seg_t             seg,
    output logic [COL_W-1:0] col
);
    localparam int DARK_START   = PRESCAN_LEN;
    localparam int ISOL_START   = DARK_START + DARK_LEN;
    localparam int USEFUL_START = ISOL_START + ISOL_LEN;

    int p;
    int useful_end;

    always_comb begin
        p          = int'(pos);
        useful_end = USEFUL_START + (split_out ? USEFUL_LEN / 2 : USEFUL_LEN);
        col        = '0;
        seg.useful = 1'b0;
        if (p < DARK_START) begin
            seg.region = RGN_PRESCAN;
        end else if (p < ISOL_START) begin
            seg.region = RGN_DARK;
        end else if (p < USEFUL_START) begin
            seg.region = RGN_ISOL;
        end else if (p < useful_end) begin
            seg.region = RGN_USEFUL;
            seg.useful = 1'b1;
            col        = COL_W'(p - USEFUL_START);
        end else begin
            seg.region = RGN_OVERRUN;
        end
    end

endmodule

// File: rtl/rdo_pixel_tagger.sv
module rdo_pixel_tagger
    import rdo_tag_pkg::*;
#(
    parameter int PRESCAN_LEN = PRESCAN_LEN_D,
    parameter int DARK_LEN    = DARK_LEN_D,
    parameter int ISOL_LEN    = ISOL_LEN_D,
    parameter int USEFUL_LEN  = USEFUL_LEN_D,
    parameter int LINES_TOTAL = LINES_TOTAL_D,
    parameter int PAD_LINES   = PAD_LINES_D,
    parameter int COL_W       = $clog2(USEFUL_LEN)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_stb,
    input  logic             line_start,
    input  logic             frame_start,
    input  logic             split_out,
    output logic             tag_valid,
    output logic [2:0]       tag_region,
    output logic [1:0]       tag_colour,
    output logic [COL_W-1:0] tag_col,
    output logic             tag_dummy
);
    localparam int LINE_MAX = PRESCAN_LEN + DARK_LEN + ISOL_LEN + USEFUL_LEN;
    localparam int POS_W    = $clog2(LINE_MAX + 1);

    logic [POS_W-1:0] pos;
    logic             line_pad;
    logic             row_odd;
    seg_t             seg;
    logic [COL_W-1:0] col;
    logic             accept;

    rdo_line_track #(
        .LINES_TOTAL (LINES_TOTAL),
        .PAD_LINES   (PAD_LINES)
    ) u_lines (
        .clk         (clk),
        .rst         (rst),
        .line_start  (line_start),
        .frame_start (frame_start),
        .line_pad    (line_pad),
        .row_odd     (row_odd)
    );

    rdo_pos_count #(
        .LINE_MAX (LINE_MAX),
        .POS_W    (POS_W)
    ) u_pos (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .pix_stb    (pix_stb),
        .pos        (pos)
    );

    rdo_region_map #(
        .PRESCAN_LEN (PRESCAN_LEN),
        .DARK_LEN    (DARK_LEN),
        .ISOL_LEN    (ISOL_LEN),
        .USEFUL_LEN  (USEFUL_LEN),
        .POS_W       (POS_W),
        .COL_W       (COL_W)
    ) u_map (
        .pos       (pos),
        .split_out (split_out),
        .seg       (seg),
        .col       (col)
    );

    assign accept = pix_stb & ~line_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_valid  <= 1'b0;
            tag_region <= RGN_PRESCAN;
            tag_colour <= CLR_RED;
            tag_col    <= '0;
            tag_dummy  <= 1'b0;
        end else begin
            tag_valid <= accept;
            if (accept) begin
                tag_region <= seg.region;
                tag_colour <= (seg.useful && !line_pad) ? site_colour(row_odd, col[0]) : CLR_RED;
                tag_col    <= col;
                tag_dummy  <= line_pad;
            end
        end
    end

    // R2: an accepted strobe yields a tag on the next cycle
    assert_tag_follows_R2: assert property (@(posedge clk) disable iff (rst)
        (pix_stb && !line_start) |=> tag_valid);

    // R6: a strobe coinciding with a line pulse is dropped
    assert_drop_on_line_R6: assert property (@(posedge clk) disable iff (rst)
        line_start |=> !tag_valid);

    // R9: colour code 3 is never produced
    assert_colour_code_R9: assert property (@(posedge clk) disable iff (rst)
        tag_valid |-> tag_colour != 2'd3);

    // R10: no colour or column outside the useful segment
    assert_nonuseful_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (tag_valid && tag_region != 3'd3) |-> (tag_colour == 2'd0 && tag_col == '0));

    // R9: adjacent useful columns of an image row differ in colour
    assert_adjacent_differ_R9: assert property (@(posedge clk) disable iff (rst)
        (tag_valid && tag_region == 3'd3 && !tag_dummy &&
         $past(tag_valid) && $past(tag_region) == 3'd3 && !$past(tag_dummy) &&
         tag_col == $past(tag_col) + 1'b1) |-> tag_colour != $past(tag_colour));

endmodule

// File: tb/test_rdo_pixel_tagger.sv
`timescale 1ns/1ps
module test_rdo_pixel_tagger;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pix_stb = 1'b0;
    logic        line_start = 1'b0;
    logic        frame_start = 1'b0;
    logic        split_out = 1'b0;
    logic        tag_valid;
    logic [2:0]  tag_region;
    logic [1:0]  tag_colour;
    logic [11:0] tag_col;
    logic        tag_dummy;

    always #10 clk = ~clk;

    rdo_pixel_tagger i_rdo_pixel_tagger (
        .clk         (clk),
        .rst         (rst),
        .pix_stb     (pix_stb),
        .line_start  (line_start),
        .frame_start (frame_start),
        .split_out   (split_out),
        .tag_valid   (tag_valid),
        .tag_region  (tag_region),
        .tag_colour  (tag_colour),
        .tag_col     (tag_col),
        .tag_dummy   (tag_dummy)
    );

    typedef struct packed {
        logic [2:0]  rgn;
        logic [1:0]  clr;
        logic [11:0] col;
        logic        dum;
    } exp_t;

    exp_t  exp_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    int    m_line   = 0;
    int    m_next   = 0;
    int    m_pos    = 0;
    string cur_req  = "R2";

    function automatic exp_t model();
        exp_t e;
        int   ulen;
        int   c;
        ulen  = split_out ? 1150 : 2300;
        e     = '0;
        e.dum = (m_line < 4) || (m_line >= 3504);
        if (m_pos < 12)             e.rgn = 3'd0;
        else if (m_pos < 28)        e.rgn = 3'd1;
        else if (m_pos < 36)        e.rgn = 3'd2;
        else if (m_pos < 36 + ulen) e.rgn = 3'd3;
        else                        e.rgn = 3'd4;
        if (e.rgn == 3'd3) begin
            c     = m_pos - 36;
            e.col = 12'(c);
            if (!e.dum) begin
                if (((m_line - 4) % 2) == 0) e.clr = (c % 2 == 1) ? 2'd1 : 2'd2;
                else                         e.clr = (c % 2 == 1) ? 2'd0 : 2'd1;
            end
        end
        return e;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pops one expected tag per tag produced
    always @(negedge clk) begin
        if (!rst && tag_valid) begin
            exp_t got;
            got = {tag_region, tag_colour, tag_col, tag_dummy};
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2 R6: unexpected tag %0h expected none", got);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (got !== e) begin
                    n_fail++;
                    $display("FAIL %s: line %0d got %0h expected %0h", cur_req, m_line, got, e);
                end
            end
        end
    end

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            pix_stb = 1'b1;
            exp_q.push_back(model());
            if (m_pos < 2336) m_pos++;
        end
        @(posedge clk); #2;
        pix_stb = 1'b0;
    endtask

    task automatic lstart();
        @(posedge clk); #2;
        line_start = 1'b1;
        @(posedge clk); #2;
        line_start = 1'b0;
        m_line = m_next;
        m_next++;
        m_pos = 0;
    endtask

    task automatic fstart(input logic with_line);
        @(posedge clk); #2;
        frame_start = 1'b1;
        line_start  = with_line;
        @(posedge clk); #2;
        frame_start = 1'b0;
        line_start  = 1'b0;
        if (with_line) begin
            m_line = 0; m_next = 1; m_pos = 0;
        end else begin
            m_next = 0;
        end
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
        check("R2 queue drained", 32'(exp_q.size()), 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 valid in reset", 32'(tag_valid), 32'd0);
        #2 rst = 1'b0;
        @(negedge clk);
        check("R1 valid", 32'(tag_valid), 32'd0);
        check("R1 region", 32'(tag_region), 32'd0);
        check("R1 colour", 32'(tag_colour), 32'd0);
        check("R1 col", 32'(tag_col), 32'd0);
        check("R1 dummy", 32'(tag_dummy), 32'd0);

        // R2: single strobe, tag only after the capturing edge
        cur_req = "R2";
        @(posedge clk); #2;
        pix_stb = 1'b1;
        exp_q.push_back(model());
        m_pos++;
        @(negedge clk);
        check("R2 no tag before edge", 32'(tag_valid), 32'd0);
        @(posedge clk); #2;
        pix_stb = 1'b0;
        @(negedge clk);
        check("R2 tag after edge", 32'(tag_valid), 32'd1);
        @(negedge clk);
        check("R2 single pulse", 32'(tag_valid), 32'd0);

        // R8: padding line 0, full width including overrun
        fstart(1'b0);
        lstart();
        cur_req = "R3 R4 R5 R8";
        strobes(2340);
        drain();

        // R9: first image row, full width
        lstart(); lstart(); lstart();
        lstart();
        cur_req = "R3 R4 R5 R9";
        strobes(2338);
        drain();

        // R4: split readout, odd row
        split_out = 1'b1;
        lstart();
        cur_req = "R4 R5 R9 R10";
        strobes(36 + 1150 + 3);
        drain();
        split_out = 1'b0;

        // R6: line pulse mid-line with a coincident strobe
        lstart();
        cur_req = "R6";
        strobes(20);
        @(posedge clk); #2;
        pix_stb = 1'b1; line_start = 1'b1;
        @(posedge clk); #2;
        pix_stb = 1'b0; line_start = 1'b0;
        m_line = m_next; m_next++; m_pos = 0;
        @(negedge clk);
        check("R6 coincident strobe dropped", 32'(tag_valid), 32'd0);
        cur_req = "R6 R9";
        strobes(40);
        drain();

        // Walk to the last image line
        while (m_next < 3503) lstart();
        lstart();
        cur_req = "R8 R9 last image";
        strobes(40);
        lstart();
        cur_req = "R8 bottom padding";
        strobes(40);
        lstart(); lstart(); lstart();
        strobes(40);
        lstart();
        strobes(2);
        drain();

        // R7: frame pulse together with a line pulse
        fstart(1'b1);
        cur_req = "R7 R8";
        strobes(40);
        lstart(); lstart(); lstart(); lstart();
        cur_req = "R7 R9";
        strobes(40);
        drain();

        // R7: frame pulse alone, then a line pulse
        fstart(1'b0);
        lstart();
        cur_req = "R7 R8";
        strobes(40);
        drain();

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule